// File: doc/BRIEF.md
# Sample RAM Transfer Register Front End

This block sits between a 16-bit host register bus and the local sample memory of a sound unit. The host sets a start location through an address register and then streams halfwords into the sample memory through a single data port. The block keeps its own pointer and steps it forward after every data write, so the host never supplies per-word addresses. A control word carries a two-bit transfer mode. When that mode selects one of the two DMA directions, the block raises a request line towards the system DMA engine.

The address register counts in units of 8 bytes, and the block scales it into its internal pointer. The pointer is held in halfword units and wraps at the end of the memory. A status register is read-only. The data port always reads back all ones. A separate read port lets the voice engine, which lies outside this block, fetch stored halfwords. Register reads return data one cycle after the read strobe.

Top module: `snd_xfer_top`

## Requirements
- R1: After reset, the control word, the stored transfer address, the status word, the read data output, the internal pointer and `dma_req` are all zero.
- R2: A write to offset 0x1A6 stores the 16-bit value, and a later read of 0x1A6 returns it unchanged.
- R3: A write to offset 0x1A6 with value V makes the next data write land at halfword index (V*4) modulo the memory size in halfwords. This is byte address V*8.
- R4: Each write to offset 0x1A8 stores the value at the current halfword index and then advances the index by one. The index wraps from the last halfword to halfword 0.
- R5: A read of offset 0x1A8 returns 0xFFFF and does not move the pointer.
- R6: A write to offset 0x1AA replaces all 16 bits of the control word, and a read of 0x1AA returns the whole word.
- R7: `dma_req` is high exactly when control bits 5:4 hold 2 (DMA write) or 3 (DMA read), and low for 0 (stop) or 1 (manual write). It follows the new value from the clock edge of the control write.
- R8: Offset 0x1AE reads the status word, which stays zero. Writes to 0x1AE change neither the control word, the pointer nor `dma_req`.
- R9: A read of any other offset returns 0xFFFF. A write to any other offset changes no register, no pointer and no memory word.
- R10: `bus_rdata` takes the selected value on the clock edge where `bus_rd` is high and holds it while `bus_rd` is low.
- R11: `voice_data` shows the memory halfword at `voice_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte offset from the unit base |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| dma_req | output | 1 | DMA request derived from the transfer mode |
| voice_addr | input | WORD_AW (11) | Halfword index for the voice read port |
| voice_data | output | 16 | Halfword read from the memory, one cycle later |

## Verification
The internal pointer cannot be seen directly at the ports. A wrong pointer value stays hidden until the memory is read through the voice port, and then it shows up as data at the wrong index. The bench therefore replays every data write into its own memory model and reads back every word it wrote. A wrong control or mode decode shows up on `dma_req` in the same cycle as the faulty edge, and on a control readback one cycle after the read strobe. A read mux error corrupts `bus_rdata` on the cycle after the strobe.

// File: rtl/snd_xfer_pkg.sv
package snd_xfer_pkg;
  localparam int OFFS_W = 10;
  localparam logic [OFFS_W-1:0] OFFS_XADDR  = 10'h1A6;
  localparam logic [OFFS_W-1:0] OFFS_XDATA  = 10'h1A8;
  localparam logic [OFFS_W-1:0] OFFS_CTRL   = 10'h1AA;
  localparam logic [OFFS_W-1:0] OFFS_STATUS = 10'h1AE;

  typedef enum logic [1:0] {
    XM_STOP   = 2'd0,
    XM_MANUAL = 2'd1,
    XM_DMA_WR = 2'd2,
    XM_DMA_RD = 2'd3
  } xfer_mode_e;

  localparam int MODE_LSB = 4;

  function automatic logic mode_wants_dma(logic [15:0] ctrl);
    xfer_mode_e m;
    m = xfer_mode_e'(ctrl[MODE_LSB+1:MODE_LSB]);
    return (m == XM_DMA_WR) || (m == XM_DMA_RD);
  endfunction
endpackage

// File: rtl/snd_xfer_regs.sv
module snd_xfer_regs
  import snd_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_ev,
  input  logic        wr_xaddr_ev,
  input  logic        wr_ctrl_ev,
  input  logic [OFFS_W-1:0] rd_offs,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        dma_req
);
  logic [15:0] ctrl_q, xaddr_q, status_q, rdata_q, rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      xaddr_q  <= '0;
      status_q <= '0;
    end else begin
      if (wr_ctrl_ev)  ctrl_q  <= wdata;
      if (wr_xaddr_ev) xaddr_q <= wdata;
    end
  end

  always_comb begin
    case (rd_offs)
      OFFS_XADDR:  rd_mux = xaddr_q;
      OFFS_CTRL:   rd_mux = ctrl_q;
      OFFS_STATUS: rd_mux = status_q;
      default:     rd_mux = 16'hFFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_ev) rdata_q <= rd_mux;
  end

  assign rdata   = rdata_q;
  assign dma_req = mode_wants_dma(ctrl_q);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(rdata_q));
endmodule

// File: rtl/snd_xfer_ptr.sv
module snd_xfer_ptr #(
  parameter int WORD_AW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_ev,
  input  logic               step_ev,
  input  logic [15:0]        load_val,
  output logic [WORD_AW-1:0] wptr
);
  function automatic logic [WORD_AW-1:0] scale_to_word(logic [15:0] v);
    return WORD_AW'({v, 2'b00});
  endfunction

  function automatic logic [WORD_AW-1:0] advance(logic [WORD_AW-1:0] p);
    return p + WORD_AW'(1);
  endfunction

  logic [WORD_AW-1:0] wptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       wptr_q <= '0;
    else if (load_ev) wptr_q <= scale_to_word(load_val);
    else if (step_ev) wptr_q <= advance(wptr_q);
  end

  assign wptr = wptr_q;
endmodule

// File: rtl/snd_xfer_ram.sv
module snd_xfer_ram #(
  parameter int WORD_AW = 11
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WORD_AW-1:0] waddr,
  input  logic [15:0]        wdata,
  input  logic [WORD_AW-1:0] raddr,
  output logic [15:0]        rdata
);
  localparam int WORDS = 1 << WORD_AW;
  logic [15:0] mem [WORDS];
  logic [15:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/snd_xfer_top.sv
module snd_xfer_top
  import snd_xfer_pkg::*;
#(
  parameter int WORD_AW = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [9:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  output logic               dma_req,
  input  logic [WORD_AW-1:0] voice_addr,
  output logic [15:0]        voice_data
);
  logic wr_xaddr_ev, wr_xdata_ev, wr_ctrl_ev, wr_status_ev, rd_ev;
  logic rd_xdata_ev, rd_ctrl_ev, rd_unmapped_ev, offs_mapped;
  logic [WORD_AW-1:0] wptr;

  assign offs_mapped    = (bus_addr == OFFS_XADDR) || (bus_addr == OFFS_XDATA) ||
                          (bus_addr == OFFS_CTRL)  || (bus_addr == OFFS_STATUS);
  assign wr_xaddr_ev    = bus_wr && (bus_addr == OFFS_XADDR);
  assign wr_xdata_ev    = bus_wr && (bus_addr == OFFS_XDATA);
  assign wr_ctrl_ev     = bus_wr && (bus_addr == OFFS_CTRL);
  assign wr_status_ev   = bus_wr && (bus_addr == OFFS_STATUS);
  assign rd_ev          = bus_rd;
  assign rd_xdata_ev    = bus_rd && (bus_addr == OFFS_XDATA);
  assign rd_ctrl_ev     = bus_rd && !bus_wr && (bus_addr == OFFS_CTRL);
  assign rd_unmapped_ev = bus_rd && !offs_mapped;

  snd_xfer_regs u_regs (
    .clk, .rst_n, .rd_ev, .wr_xaddr_ev, .wr_ctrl_ev,
    .rd_offs(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata), .dma_req
  );

  snd_xfer_ptr #(.WORD_AW(WORD_AW)) u_ptr (
    .clk, .rst_n, .load_ev(wr_xaddr_ev), .step_ev(wr_xdata_ev),
    .load_val(bus_wdata), .wptr
  );

  snd_xfer_ram #(.WORD_AW(WORD_AW)) u_ram (
    .clk, .we(wr_xdata_ev), .waddr(wptr), .wdata(bus_wdata),
    .raddr(voice_addr), .rdata(voice_data)
  );

  // R3
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_xaddr_ev |=> wptr == WORD_AW'({$past(bus_wdata), 2'b00}));
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_xdata_ev && !wr_xaddr_ev) |=> wptr == $past(wptr) + WORD_AW'(1));
  // R5
  data_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_xdata_ev |=> bus_rdata == 16'hFFFF);
  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped_ev |=> bus_rdata == 16'hFFFF);
  // R7
  dma_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl_ev |=> bus_rdata[MODE_LSB+1] == dma_req);
  // R8
  status_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status_ev && !bus_rd) |=> $stable(dma_req) && wptr == $past(wptr));
endmodule

// File: tb/snd_xfer_top_tb.sv
module snd_xfer_top_tb;
  localparam int WORD_AW = 11;
  localparam int WORDS = 1 << WORD_AW;
  localparam logic [9:0] A_XADDR = 10'h1A6, A_XDATA = 10'h1A8,
                         A_CTRL = 10'h1AA, A_STAT = 10'h1AE;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [9:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata, voice_data;
  logic dma_req;
  logic [WORD_AW-1:0] voice_addr = '0;

  int n_tests = 0, n_fail = 0;
  logic [15:0] m_mem [WORDS];
  bit m_valid [WORDS];
  int m_ptr = 0;
  logic [15:0] m_ctrl = 0, m_xaddr = 0;

  always #5 clk = ~clk;

  snd_xfer_top #(.WORD_AW(WORD_AW)) u_dut (.*);

  function automatic int exp_index(logic [15:0] v);
    return (int'(v) * 8 / 2) % WORDS;
  endfunction
  function automatic bit exp_dma(logic [15:0] c);
    return (c >> 4) % 4 >= 2;
  endfunction
  function automatic bit is_mapped(logic [9:0] a);
    return a == A_XADDR || a == A_XDATA || a == A_CTRL || a == A_STAT;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    if (a == A_XADDR) begin m_xaddr = d; m_ptr = exp_index(d); end
    else if (a == A_XDATA) begin
      m_mem[m_ptr] = d; m_valid[m_ptr] = 1; m_ptr = (m_ptr + 1) % WORDS;
    end else if (a == A_CTRL) m_ctrl = d;
    check("R7 dma_req", {15'd0, dma_req}, {15'd0, exp_dma(m_ctrl)});
  endtask

  task automatic rd(logic [9:0] a, output logic [15:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic vread(int idx, output logic [15:0] v);
    @(negedge clk); voice_addr = WORD_AW'(idx);
    @(negedge clk); v = voice_data;
  endtask

  initial begin
    #(150000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int seed = 32'h5EED;
    void'($urandom(seed));
    for (int i = 0; i < WORDS; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 dma_req", {15'd0, dma_req}, 16'd0);
    check("R1 rdata", bus_rdata, 16'd0);
    rst_n = 1;
    rd(A_CTRL, v);  check("R1 ctrl", v, 16'd0);
    rd(A_XADDR, v); check("R1 xaddr", v, 16'd0);
    rd(A_STAT, v);  check("R1 status", v, 16'd0);
    wr(A_XDATA, 16'hA5A5);
    vread(0, v); check("R1 pointer starts at 0 / R11", v, 16'hA5A5);

    // R10 hold: no strobe, value held
    rd(A_XADDR, v);
    repeat (3) @(negedge clk);
    check("R10 hold", bus_rdata, v);

    // R6/R7 every mode
    for (int m = 0; m < 4; m++) begin
      wr(A_CTRL, 16'hC30F | 16'(m << 4));
      rd(A_CTRL, v); check("R6 ctrl readback", v, 16'hC30F | 16'(m << 4));
    end
    wr(A_CTRL, 16'h0000);

    // R8 status write ignored
    wr(A_CTRL, 16'h0020);
    wr(A_STAT, 16'hFFFF);
    check("R8 dma unchanged", {15'd0, dma_req}, 16'd1);
    rd(A_STAT, v); check("R8 status", v, 16'd0);
    rd(A_CTRL, v); check("R8 ctrl unchanged", v, 16'h0020);

    // R4 wrap: load near end
    wr(A_XADDR, 16'(WORDS / 4 - 1));
    rd(A_XADDR, v); check("R2 xaddr readback", v, 16'(WORDS / 4 - 1));
    for (int i = 0; i < 5; i++) wr(A_XDATA, 16'h1000 + 16'(i));
    vread(WORDS - 1, v); check("R4 last word", v, 16'h1003);
    vread(0, v); check("R4 wrapped word", v, 16'h1004);

    // R5 data read does not move pointer; R9 unmapped
    wr(A_XADDR, 16'hFFFF);
    rd(A_XDATA, v); check("R5 data read", v, 16'hFFFF);
    wr(10'h1A0, 16'h7777);
    rd(10'h1A0, v); check("R9 unmapped read", v, 16'hFFFF);
    rd(A_XADDR, v); check("R9 xaddr unchanged", v, 16'hFFFF);
    wr(A_XDATA, 16'hBEEF);
    vread(exp_index(16'hFFFF), v); check("R3/R5 landing", v, 16'hBEEF);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      int k = $urandom_range(0, 9);
      logic [9:0] a;
      logic [15:0] d = 16'($urandom);
      if (k < 5) a = A_XDATA;
      else if (k == 5) a = A_XADDR;
      else if (k == 6) a = A_CTRL;
      else if (k == 7) a = A_STAT;
      else begin
        a = 10'($urandom);
        if (is_mapped(a)) a = 10'h3F0;
      end
      if ($urandom_range(0, 3) == 0) begin
        rd(a, v);
        if (a == A_XADDR) check("R2 rand", v, m_xaddr);
        else if (a == A_CTRL) check("R6 rand", v, m_ctrl);
        else if (a == A_STAT) check("R8 rand", v, 16'd0);
        else if (a == A_XDATA) check("R5 rand", v, 16'hFFFF);
        else check("R9 rand", v, 16'hFFFF);
      end else wr(a, d);
    end

    // R4/R11 full memory sweep
    for (int i = 0; i < WORDS; i++)
      if (m_valid[i]) begin vread(i, v); check("R4 mem", v, m_mem[i]); end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule